// File: doc/BRIEF.md
# Uncorrectable Error Header Log with Pending-Record Queue

This block keeps the uncorrectable-error logging state of one PCIe function: the uncorrectable status register, a pointer to the status bit of the first logged error, a four-dword header log, a four-dword TLP prefix log, and a flag that marks the prefix log as valid. An error source offers a record with exactly one status bit, an optional header and an optional prefix. If there is no pending first error, the record goes straight into the visible log. If there is one and multiple header recording is on, the record waits in a first-in first-out queue.

Software clears status bits with write-one-to-clear writes. After each write the block spends one evaluation cycle deciding what the write means. If the first-error bit is gone, the block either empties the log or replays the oldest queued record into it. If the first-error bit is still set, the block either sets the queued records' status bits again or, with multiple header recording off, drops the queue. The control is a two-state machine. ST_IDLE accepts records and writes, and a write moves it to ST_EVAL. ST_EVAL applies the decision and always returns to ST_IDLE on the next edge.

Top module: `uerr_hdr_log`

## Requirements
- R1: A record whose status vector has zero bits or more than one bit set is rejected: `rec_reject` is high for one cycle after the accepting edge, and the status register and log do not change.
- R2: An accepted record sets its status bit. It is written into the visible log when multiple header recording is off, or when the status bit selected by `first_ptr` is clear at the time the record arrives. This holds even if an earlier error is still logged.
- R3: With multiple header recording on and the first-error bit set, a record is queued and the log does not change. If the queue already holds `Q_DEPTH` records, the record is dropped and `log_overflow` is high for one cycle. The record's status bit is set in both cases.
- R4: Logging a record sets `first_ptr` to the bit index of its status bit. With the header flag set, header dword i (bits 32i+31..32i) is stored with its four bytes reversed, so byte 0 goes to bits 31..24. Without the header flag, the header log is zero.
- R5: The prefix log is loaded with the same per-dword byte reversal, and `pfx_flag` is set, only when the record carries a prefix and `e2e_pfx_sup` is high. Otherwise the prefix log is zero and `pfx_flag` is clear.
- R6: A status write clears each bit written as one and leaves every other bit unchanged. If the write clears the first-error bit and either multiple header recording is off or the queue is empty, the evaluation cycle zeroes `first_ptr`, `pfx_flag`, the header log and the prefix log.
- R7: If a write clears the first-error bit, multiple header recording is on and the queue is not empty, the evaluation cycle sets the status bits of all queued records again. It then pops the oldest record and logs it. Replay order is arrival order.
- R8: If the first-error bit is still set after a write and multiple header recording is on, the evaluation cycle sets the status bits of all queued records again, which undoes any clearing of them.
- R9: If the first-error bit is still set after a write and multiple header recording is off, the evaluation cycle empties the queue.
- R10: `mhr_capable` is high only when `Q_DEPTH` is greater than zero. With `Q_DEPTH` = 0, `mhr_en` has no effect and every accepted record is logged directly.
- R11: `busy` is high for exactly the one evaluation cycle after a write. Records offered while `busy` is high are ignored. A write and a record in the same idle cycle: the write is taken and the record is ignored.
- R12: Reset clears the status register, the log, the prefix flag and the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mhr_en | input | 1 | Multiple header recording enable |
| e2e_pfx_sup | input | 1 | End-to-end TLP prefix support advertised |
| rec_valid | input | 1 | Record offered this cycle |
| rec_status | input | 32 | Record status vector (must be one-hot) |
| rec_hdr_valid | input | 1 | Record header words are valid |
| rec_hdr | input | 128 | Record header, dword i at bits 32i+31..32i |
| rec_pfx_valid | input | 1 | Record carries TLP prefix words |
| rec_pfx | input | 128 | Record prefix, dword i at bits 32i+31..32i |
| sts_wr_en | input | 1 | Status register write strobe |
| sts_wr_clr | input | 32 | Write-one-to-clear mask |
| first_ptr | output | 5 | Bit index of the logged first error |
| pfx_flag | output | 1 | Prefix log holds a valid prefix |
| hdr_log | output | 128 | Header log, byte-reversed dwords |
| pfx_log | output | 128 | Prefix log, byte-reversed dwords |
| unc_status | output | 32 | Uncorrectable status register |
| mhr_capable | output | 1 | Queue present, multiple header recording possible |
| busy | output | 1 | Evaluation cycle after a status write |
| rec_reject | output | 1 | One-cycle pulse: record rejected as not one-hot |
| log_overflow | output | 1 | One-cycle pulse: queue full, record dropped |

## Verification
The bench builds the main instance with `Q_DEPTH` = 2. With that depth, a third pending error reaches the full-queue overflow path, and two pops in a row show arrival-order replay and the re-set of queued status bits. A second instance is built with `Q_DEPTH` = 0 and driven by the same inputs. Its log diverges at the first error that the deep instance queues, which shows that the enable is ignored when no queue exists.

// File: rtl/uerr_pkg.sv
package uerr_pkg;
    localparam int ERR_BITS  = 32;
    localparam int PTR_W     = $clog2(ERR_BITS);
    localparam int LOG_DWS   = 4;
    localparam int LOG_BITS  = 32 * LOG_DWS;

    typedef struct packed {
        logic [PTR_W-1:0]    idx;
        logic                hdr_ok;
        logic [LOG_BITS-1:0] hdr;
        logic                pfx_ok;
        logic [LOG_BITS-1:0] pfx;
    } err_rec_t;

    typedef enum logic {ST_IDLE, ST_EVAL} ctl_state_e;

    // reverse the bytes within each dword
    function automatic logic [LOG_BITS-1:0] dword_bswap(input logic [LOG_BITS-1:0] v);
        logic [LOG_BITS-1:0] r;
        for (int d = 0; d < LOG_DWS; d++) begin
            for (int b = 0; b < 4; b++) begin
                r[32*d + 8*b +: 8] = v[32*d + 8*(3-b) +: 8];
            end
        end
        return r;
    endfunction

    function automatic logic [PTR_W-1:0] bit_index(input logic [ERR_BITS-1:0] v);
        logic [PTR_W-1:0] r;
        r = '0;
        for (int i = 0; i < ERR_BITS; i++) begin
            if (v[i]) r = PTR_W'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/uerr_rec_fifo.sv
module uerr_rec_fifo
    import uerr_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                push,
    input  logic                pop,
    input  logic                flush,
    input  err_rec_t            wr_rec,
    output err_rec_t            head_rec,
    output logic                empty,
    output logic                full,
    output logic [ERR_BITS-1:0] pend_mask
);
    localparam int QD = (DEPTH > 0) ? DEPTH : 1;
    localparam int AW = (QD > 1) ? $clog2(QD) : 1;
    localparam int CW = $clog2(QD + 1);

    err_rec_t          mem [QD];
    logic [QD-1:0]     vld;
    logic [AW-1:0]     head_q, tail_q;
    logic [CW-1:0]     cnt_q;
    logic              acc_push, acc_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(QD - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full     = (cnt_q == CW'(DEPTH));
    assign empty    = (cnt_q == '0);
    assign acc_push = push && !full && !flush;
    assign acc_pop  = pop && !empty && !flush;
    assign head_rec = mem[head_q];

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (acc_push) tail_q <= bump(tail_q);
            if (acc_pop)  head_q <= bump(head_q);
            unique case ({acc_push, acc_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    for (genvar k = 0; k < QD; k++) begin : g_ent
        err_rec_t ent;
        logic     v;
        always_ff @(posedge clk) begin
            if (acc_push && tail_q == AW'(k)) ent <= wr_rec;
        end
        always_ff @(posedge clk) begin
            if (!rst_n || flush)                      v <= 1'b0;
            else if (acc_push && tail_q == AW'(k))    v <= 1'b1;
            else if (acc_pop && head_q == AW'(k))     v <= 1'b0;
        end
        assign mem[k] = ent;
        assign vld[k] = v;
    end

    always_comb begin
        pend_mask = '0;
        for (int k = 0; k < QD; k++) begin
            if (vld[k]) pend_mask[mem[k].idx] = 1'b1;
        end
    end

    p_full_refuses_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> cnt_q == $past(cnt_q));
    p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (empty && pend_mask == '0));
endmodule

// File: rtl/uerr_log_regs.sv
module uerr_log_regs
    import uerr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                clear,
    input  err_rec_t            rec,
    input  logic                pfx_sup,
    output logic [PTR_W-1:0]    first_ptr,
    output logic                pfx_flag,
    output logic [LOG_BITS-1:0] hdr_log,
    output logic [LOG_BITS-1:0] pfx_log
);
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            first_ptr <= '0;
            pfx_flag  <= 1'b0;
            hdr_log   <= '0;
            pfx_log   <= '0;
        end else if (load) begin
            first_ptr <= rec.idx;
            hdr_log   <= rec.hdr_ok ? dword_bswap(rec.hdr) : '0;
            if (rec.pfx_ok && pfx_sup) begin
                pfx_log  <= dword_bswap(rec.pfx);
                pfx_flag <= 1'b1;
            end else begin
                pfx_log  <= '0;
                pfx_flag <= 1'b0;
            end
        end
    end

    p_clear_zeroes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (first_ptr == '0 && !pfx_flag && hdr_log == '0 && pfx_log == '0));
    p_no_pfx_unsup_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clear && !pfx_sup) |=> (!pfx_flag && pfx_log == '0));
endmodule

// File: rtl/uerr_hdr_log.sv
module uerr_hdr_log
    import uerr_pkg::*;
#(
    parameter int Q_DEPTH = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mhr_en,
    input  logic                e2e_pfx_sup,
    input  logic                rec_valid,
    input  logic [31:0]         rec_status,
    input  logic                rec_hdr_valid,
    input  logic [127:0]        rec_hdr,
    input  logic                rec_pfx_valid,
    input  logic [127:0]        rec_pfx,
    input  logic                sts_wr_en,
    input  logic [31:0]         sts_wr_clr,
    output logic [4:0]          first_ptr,
    output logic                pfx_flag,
    output logic [127:0]        hdr_log,
    output logic [127:0]        pfx_log,
    output logic [31:0]         unc_status,
    output logic                mhr_capable,
    output logic                busy,
    output logic                rec_reject,
    output logic                log_overflow
);
    localparam logic HAS_Q = (Q_DEPTH > 0);

    ctl_state_e          state_q, state_d;
    logic [ERR_BITS-1:0] status_q;
    logic                mhr_eff, first_pend, in_idle, in_eval;
    logic                take_rec, rec_ok, queue_it;
    logic                do_push, do_pop, do_flush, restore, log_new, log_clear;
    logic                q_empty, q_full;
    logic [ERR_BITS-1:0] q_mask;
    err_rec_t            new_rec, q_head, log_rec;
    logic [PTR_W-1:0]    head_idx;

    assign mhr_eff    = mhr_en && HAS_Q;
    assign in_idle    = (state_q == ST_IDLE);
    assign in_eval    = (state_q == ST_EVAL);
    assign first_pend = status_q[first_ptr];
    assign rec_ok     = (rec_status != '0) && ((rec_status & (rec_status - 1'b1)) == '0);
    assign take_rec   = in_idle && !sts_wr_en && rec_valid;
    assign queue_it   = mhr_eff && first_pend;

    assign new_rec = '{idx: bit_index(rec_status), hdr_ok: rec_hdr_valid, hdr: rec_hdr,
                       pfx_ok: rec_pfx_valid, pfx: rec_pfx};

    assign do_push   = take_rec && rec_ok && queue_it && !q_full;
    assign log_new   = take_rec && rec_ok && !queue_it;
    assign log_clear = in_eval && !first_pend && (!mhr_eff || q_empty);
    assign do_pop    = in_eval && !first_pend && mhr_eff && !q_empty;
    assign do_flush  = in_eval && first_pend && !mhr_eff;
    assign restore   = (in_eval && first_pend && mhr_eff) || do_pop;
    assign log_rec   = do_pop ? q_head : new_rec;
    assign head_idx  = q_head.idx;

    uerr_rec_fifo #(.DEPTH(Q_DEPTH)) fifo_i (
        .clk(clk), .rst_n(rst_n), .push(do_push), .pop(do_pop), .flush(do_flush),
        .wr_rec(new_rec), .head_rec(q_head), .empty(q_empty), .full(q_full),
        .pend_mask(q_mask)
    );

    uerr_log_regs log_i (
        .clk(clk), .rst_n(rst_n), .load(log_new || do_pop), .clear(log_clear),
        .rec(log_rec), .pfx_sup(e2e_pfx_sup), .first_ptr(first_ptr),
        .pfx_flag(pfx_flag), .hdr_log(hdr_log), .pfx_log(pfx_log)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (sts_wr_en) state_d = ST_EVAL;
            ST_EVAL: state_d = ST_IDLE;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q     <= '0;
            rec_reject   <= 1'b0;
            log_overflow <= 1'b0;
        end else begin
            rec_reject   <= take_rec && !rec_ok;
            log_overflow <= take_rec && rec_ok && queue_it && q_full;
            if (in_idle && sts_wr_en)  status_q <= status_q & ~sts_wr_clr;
            else if (take_rec && rec_ok) status_q <= status_q | rec_status;
            else if (restore)          status_q <= status_q | q_mask;
        end
    end

    assign unc_status  = status_q;
    assign busy        = in_eval;
    assign mhr_capable = HAS_Q;

    p_reject_keeps_status_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rec_reject |-> unc_status == $past(unc_status));
    p_overflow_only_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        log_overflow |-> $past(q_full));
    p_replay_ptr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        do_pop |=> first_ptr == $past(head_idx));
    p_restore_queued_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_eval && first_pend && mhr_eff) |=> ((unc_status & $past(q_mask)) == $past(q_mask)));
    p_eval_one_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);
endmodule

// File: tb/uerr_hdr_log_tb.sv
`timescale 1ns/1ps
module uerr_hdr_log_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mhr_en = 1'b1, e2e_pfx_sup = 1'b1;
    logic         rec_valid = 1'b0, rec_hdr_valid = 1'b0, rec_pfx_valid = 1'b0;
    logic [31:0]  rec_status = '0;
    logic [127:0] rec_hdr = '0, rec_pfx = '0;
    logic         sts_wr_en = 1'b0;
    logic [31:0]  sts_wr_clr = '0;

    logic [4:0]   first_ptr, z_first_ptr;
    logic         pfx_flag, z_pfx_flag, mhr_capable, z_mhr_capable;
    logic [127:0] hdr_log, pfx_log, z_hdr_log, z_pfx_log;
    logic [31:0]  unc_status, z_unc_status;
    logic         busy, rec_reject, log_overflow, z_busy, z_rec_reject, z_log_overflow;

    always #2.5 clk = ~clk;

    uerr_hdr_log #(.Q_DEPTH(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .mhr_en(mhr_en), .e2e_pfx_sup(e2e_pfx_sup),
        .rec_valid(rec_valid), .rec_status(rec_status), .rec_hdr_valid(rec_hdr_valid),
        .rec_hdr(rec_hdr), .rec_pfx_valid(rec_pfx_valid), .rec_pfx(rec_pfx),
        .sts_wr_en(sts_wr_en), .sts_wr_clr(sts_wr_clr), .first_ptr(first_ptr),
        .pfx_flag(pfx_flag), .hdr_log(hdr_log), .pfx_log(pfx_log), .unc_status(unc_status),
        .mhr_capable(mhr_capable), .busy(busy), .rec_reject(rec_reject),
        .log_overflow(log_overflow));

    uerr_hdr_log #(.Q_DEPTH(0)) dut0_i (
        .clk(clk), .rst_n(rst_n), .mhr_en(mhr_en), .e2e_pfx_sup(e2e_pfx_sup),
        .rec_valid(rec_valid), .rec_status(rec_status), .rec_hdr_valid(rec_hdr_valid),
        .rec_hdr(rec_hdr), .rec_pfx_valid(rec_pfx_valid), .rec_pfx(rec_pfx),
        .sts_wr_en(sts_wr_en), .sts_wr_clr(sts_wr_clr), .first_ptr(z_first_ptr),
        .pfx_flag(z_pfx_flag), .hdr_log(z_hdr_log), .pfx_log(z_pfx_log),
        .unc_status(z_unc_status), .mhr_capable(z_mhr_capable), .busy(z_busy),
        .rec_reject(z_rec_reject), .log_overflow(z_log_overflow));

    typedef struct {
        string        req;
        logic [4:0]   ptr;
        logic         flag;
        logic [127:0] hdr;
        logic [127:0] pfx;
        logic [31:0]  sts;
        logic         ovf;
        logic         rej;
    } exp_t;

    exp_t sb_q[$];
    int   n_chk = 0, n_err = 0;

    localparam logic [127:0] H_A = {32'h11223344, 32'h55667788, 32'h99AABBCC, 32'hDDEEFF00};
    localparam logic [127:0] H_B = {32'hCAFEF00D, 32'h0BADBEEF, 32'h01020304, 32'hA5A55A5A};
    localparam logic [127:0] P_A = {32'h80000001, 32'h40000002, 32'h20000003, 32'h10000004};
    localparam logic [127:0] P_C = {32'hFEDCBA98, 32'h76543210, 32'h0F1E2D3C, 32'h4B5A6978};

    function automatic logic [127:0] swap4(input logic [127:0] v);
        logic [127:0] r;
        for (int d = 0; d < 4; d++)
            r[32*d +: 32] = {v[32*d +: 8], v[32*d+8 +: 8], v[32*d+16 +: 8], v[32*d+24 +: 8]};
        return r;
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // monitor: compare each expected snapshot at the next falling edge
    always @(negedge clk) begin
        exp_t e;
        if (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            n_chk++;
            if (first_ptr !== e.ptr || pfx_flag !== e.flag || hdr_log !== e.hdr ||
                pfx_log !== e.pfx || unc_status !== e.sts || log_overflow !== e.ovf ||
                rec_reject !== e.rej) begin
                n_err++;
                $display("FAIL %s actual=ptr%0d flag%0b hdr%h pfx%h sts%h ovf%0b rej%0b expected=ptr%0d flag%0b hdr%h pfx%h sts%h ovf%0b rej%0b",
                         e.req, first_ptr, pfx_flag, hdr_log, pfx_log, unc_status, log_overflow,
                         rec_reject, e.ptr, e.flag, e.hdr, e.pfx, e.sts, e.ovf, e.rej);
            end
        end
    end

    task automatic expect_st(input string req, input logic [4:0] ptr, input logic flag,
                             input logic [127:0] hdr, input logic [127:0] pfx,
                             input logic [31:0] sts, input logic ovf, input logic rej);
        exp_t e;
        e.req = req; e.ptr = ptr; e.flag = flag; e.hdr = hdr; e.pfx = pfx;
        e.sts = sts; e.ovf = ovf; e.rej = rej;
        sb_q.push_back(e);
    endtask

    task automatic send_rec(input logic [31:0] st, input logic hv, input logic [127:0] h,
                            input logic pv, input logic [127:0] p);
        @(negedge clk);
        rec_valid = 1'b1; rec_status = st; rec_hdr_valid = hv; rec_hdr = h;
        rec_pfx_valid = pv; rec_pfx = p;
        @(posedge clk); #1;
        rec_valid = 1'b0;
    endtask

    task automatic wr_sts(input logic [31:0] m);
        @(negedge clk);
        sts_wr_en = 1'b1; sts_wr_clr = m;
        @(posedge clk); #1;
        sts_wr_en = 1'b0;
        @(posedge clk); #1;
    endtask

    initial begin
        #(5.0 * 20000);
        n_err++;
        $display("FAIL watchdog all-requirements actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1;
        expect_st("R12 reset state", 5'd0, 0, '0, '0, 32'h0, 0, 0);
        chk("R10 capable with queue", 128'(mhr_capable), 128'(1));
        chk("R10 not capable without queue", 128'(z_mhr_capable), 128'(0));

        send_rec(32'h3, 1, H_A, 1, P_A);
        expect_st("R1 two bits rejected", 5'd0, 0, '0, '0, 32'h0, 0, 1);
        send_rec(32'h0, 1, H_A, 1, P_A);
        expect_st("R1 zero bits rejected", 5'd0, 0, '0, '0, 32'h0, 0, 1);

        send_rec(32'h10, 1, H_A, 1, P_A);
        expect_st("R4 R5 first error logged", 5'd4, 1, swap4(H_A), swap4(P_A), 32'h10, 0, 0);
        send_rec(32'h80, 1, H_B, 0, '0);
        expect_st("R3 second error queued", 5'd4, 1, swap4(H_A), swap4(P_A), 32'h90, 0, 0);
        chk("R10 zero depth logs directly", 128'(z_first_ptr), 128'(7));
        send_rec(32'h200, 0, H_B, 1, P_C);
        expect_st("R3 third error queued", 5'd4, 1, swap4(H_A), swap4(P_A), 32'h290, 0, 0);
        send_rec(32'h1000, 1, H_B, 0, '0);
        expect_st("R3 full queue overflow", 5'd4, 1, swap4(H_A), swap4(P_A), 32'h1290, 1, 0);

        wr_sts(32'h280);
        expect_st("R8 queued bits restored", 5'd4, 1, swap4(H_A), swap4(P_A), 32'h1290, 0, 0);
        wr_sts(32'h10);
        expect_st("R7 oldest replayed", 5'd7, 0, swap4(H_B), '0, 32'h1280, 0, 0);
        wr_sts(32'h80);
        expect_st("R7 next replayed in order", 5'd9, 1, '0, swap4(P_C), 32'h1200, 0, 0);
        wr_sts(32'h200);
        expect_st("R6 empty queue clears log", 5'd0, 0, '0, '0, 32'h1000, 0, 0);
        wr_sts(32'h1000);
        expect_st("R6 write one clears bit", 5'd0, 0, '0, '0, 32'h0, 0, 0);

        e2e_pfx_sup = 1'b0;
        send_rec(32'h8, 1, H_A, 1, P_A);
        expect_st("R5 prefix unsupported", 5'd3, 0, swap4(H_A), '0, 32'h8, 0, 0);
        send_rec(32'h20, 1, H_B, 0, '0);
        expect_st("R3 queued for flush test", 5'd3, 0, swap4(H_A), '0, 32'h28, 0, 0);
        mhr_en = 1'b0;
        wr_sts(32'h20);
        expect_st("R9 flush keeps log", 5'd3, 0, swap4(H_A), '0, 32'h8, 0, 0);
        send_rec(32'h40, 0, H_B, 0, '0);
        expect_st("R2 direct log with recording off", 5'd6, 0, '0, '0, 32'h48, 0, 0);
        mhr_en = 1'b1;
        wr_sts(32'h40);
        expect_st("R9 queue was flushed", 5'd0, 0, '0, '0, 32'h8, 0, 0);
        wr_sts(32'h8);
        expect_st("R6 cleared again", 5'd0, 0, '0, '0, 32'h0, 0, 0);

        send_rec(32'h4, 1, H_A, 0, '0);
        expect_st("R2 logged when idle", 5'd2, 0, swap4(H_A), '0, 32'h4, 0, 0);
        @(negedge clk);
        sts_wr_en = 1'b1; sts_wr_clr = 32'h4;
        rec_valid = 1'b1; rec_status = 32'h100; rec_hdr_valid = 1'b1; rec_hdr = H_B;
        rec_pfx_valid = 1'b0;
        @(posedge clk); #1;
        sts_wr_en = 1'b0;
        @(negedge clk);
        chk("R11 busy in evaluation", 128'(busy), 128'(1));
        @(posedge clk); #1;
        rec_valid = 1'b0;
        expect_st("R11 records ignored around write", 5'd0, 0, '0, '0, 32'h0, 0, 0);
        @(negedge clk);
        chk("R11 busy one cycle", 128'(busy), 128'(0));

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule